// File: doc/BRIEF.md
# Memory Test and Initialization Sequencer

This block is a hardware engine that walks a range of 64-byte memory lines through a 64-bit request/ready master port. A line is eight 64-bit words, and the word address is the line index times eight plus the word number. The engine has three kinds of run. It can clear the range to zero so that ECC check bits start out consistent. It can run a write/read/verify test with a fixed alternating pattern followed by its inverse. It can also access a single line with a constant training pattern.

Software programs the engine through a small register port. The registers hold the first and last line of the range, the mode, halt-on-error, the choice of training constant and a go bit. Software then polls a busy flag and reads the per-byte-lane error status and a saturating mismatch counter. A mismatch in byte lane i of any compared word sets a sticky lane flag. After a read pass that leaves any lane flag set, the engine skips the remaining passes. With halt-on-error enabled, it stops on the first failing word instead.

Top module: `memtest_seq`

## Requirements
- R1: After reset the engine is idle: `mem_req` is low, and STATUS (offset 3) and COUNT (offset 4) read zero.
- R2: A run starts when CTRL (offset 0) is written with bit 8 (go) set while the stored go bit is clear and the engine is idle. Writing go again while it is already set starts nothing. STATUS bit 30 (busy) is high from the cycle after the starting write until the last beat of the run has been accepted.
- R3: Mode 0 (CTRL bits 2:0 = 0) makes one write pass of all-zero words over lines FIRST (offset 1) through LAST (offset 2) inclusive, in ascending word order, with no reads and no compare.
- R4: Mode 1 runs four passes over the range in this order: write 0x5AA55AA55AA55AA5, read and compare, write 0xA55AA55AA55AA55A, read and compare.
- R5: At the end of a read pass, if any lane error flag is set, the remaining passes are skipped and the engine goes idle.
- R6: A compared word whose byte lane i (data bits 8i+7:8i) differs from the expected byte sets STATUS bit 8+i. The flag stays set until it is cleared.
- R7: Writing STATUS with bit 12 set clears the lane flags, the mismatch counter and the illegal-mode flag.
- R8: With CTRL bit 3 (halt) set, the run ends with the first mismatching word, and no further beat is issued.
- R9: Mode 2 writes the eight words of line FIRST with a constant: 0xC33C0000C33C0000 when CTRL bit 4 is 0, and 0xAA5555AAAA5555AA when it is 1.
- R10: Mode 3 reads the eight words of line FIRST and compares each against the same constant chosen by CTRL bit 4.
- R11: COUNT increments by one for each compared word with any mismatching lane and saturates at all ones.
- R12: A go write carrying mode 4 to 7 does not raise busy or issue requests, and it sets STATUS bit 0.
- R13: While `mem_req` is high and `mem_ready` is low, the address, direction and write data are held. A beat completes in a cycle in which both are high, and read data is sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on cfg_addr) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | LINE_AW+3 | 64-bit word address |
| mem_wdata | output | 64 | Write data |
| mem_ready | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 64 | Read data, valid when a read beat is accepted |

## Verification
Register writes take effect at the next edge, so busy and the stored fields are readable at the falling edge that follows the write. Lane flags and the counter update at the edge that accepts the failing beat. When busy falls, the last memory write has already landed. The bench therefore polls busy at falling edges and compares memory contents, beat counts, STATUS and COUNT only once busy reads low. It stalls `mem_ready` one cycle in three, so every result has to come through the handshake rather than through fixed cycle counts.

// File: rtl/memtest_seq.sv
module memtest_seq #(
  parameter int LINE_AW = 16,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic [31:0]        cfg_rdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [LINE_AW+2:0] mem_addr,
  output logic [63:0]        mem_wdata,
  input  logic               mem_ready,
  input  logic [63:0]        mem_rdata
);
  localparam logic [63:0] PAT_BASE = 64'h5AA55AA55AA55AA5;
  localparam logic [63:0] PAT_INV  = ~PAT_BASE;
  localparam logic [63:0] PAT_WTR  = 64'hC33C0000C33C0000;
  localparam logic [63:0] PAT_RTR  = 64'hAA5555AAAA5555AA;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0]         mode_q;
  logic               halt_q, train_q, go_q, busy, bad_q;
  logic [LINE_AW-1:0] first_q, last_q, line_q;
  logic [2:0]         word_q;
  logic [1:0]         pass_q;
  logic [7:0]         err_q, lane_bad, lane_hit, err_nx;
  logic [CNT_W-1:0]   cnt_q;

  wire is_test   = (mode_q == 3'd1);
  wire is_single = mode_q[1];
  wire rd_pass   = is_test ? pass_q[0] : (mode_q == 3'd3);

  logic [63:0] pat;
  always_comb begin
    if (mode_q == 3'd0)  pat = '0;
    else if (is_single)  pat = train_q ? PAT_RTR : PAT_WTR;
    else                 pat = pass_q[1] ? PAT_INV : PAT_BASE;
  end

  assign mem_req   = busy;
  assign mem_we    = ~rd_pass;
  assign mem_addr  = {line_q, word_q};
  assign mem_wdata = pat;

  for (genvar i = 0; i < 8; i++) begin : g_lane
    assign lane_bad[i] = mem_rdata[8*i +: 8] != pat[8*i +: 8];
  end

  wire beat      = busy & mem_ready;
  wire mism      = beat & rd_pass & (|lane_bad);
  assign lane_hit = mism ? lane_bad : 8'h00;
  assign err_nx   = err_q | lane_hit;
  wire line_end  = (word_q == 3'd7);
  wire pass_end  = line_end & (is_single | (line_q == last_q));
  wire last_pass = is_test ? (pass_q == 2'd3) : 1'b1;
  wire done      = beat & ((halt_q & mism) |
                           (pass_end & (last_pass | (rd_pass & (|err_nx)))));

  wire ctrl_wr = cfg_we & (cfg_addr == 3'd0) & ~busy;
  wire go_edge = ctrl_wr & cfg_wdata[8] & ~go_q;
  wire start   = go_edge & ~cfg_wdata[2];
  wire bad_go  = go_edge & cfg_wdata[2];
  wire clr     = cfg_we & (cfg_addr == 3'd3) & cfg_wdata[12];
  wire unused_wdata = &{1'b0, cfg_wdata[31:13], cfg_wdata[11:9], cfg_wdata[7:5]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; halt_q <= 1'b0; train_q <= 1'b0; go_q <= 1'b0;
      first_q <= '0; last_q <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q  <= cfg_wdata[2:0];
        halt_q  <= cfg_wdata[3];
        train_q <= cfg_wdata[4];
        go_q    <= cfg_wdata[8];
      end
      if (cfg_we && cfg_addr == 3'd1 && !busy) first_q <= cfg_wdata[LINE_AW-1:0];
      if (cfg_we && cfg_addr == 3'd2 && !busy) last_q  <= cfg_wdata[LINE_AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; pass_q <= '0; line_q <= '0; word_q <= '0;
    end else if (start) begin
      busy <= 1'b1; pass_q <= '0; line_q <= first_q; word_q <= '0;
    end else if (done) begin
      busy <= 1'b0;
    end else if (beat) begin
      word_q <= word_q + 3'd1;
      if (pass_end) begin
        pass_q <= pass_q + 2'd1;
        line_q <= first_q;
      end else if (line_end) begin
        line_q <= line_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      err_q <= '0; cnt_q <= '0; bad_q <= 1'b0;
    end else begin
      err_q <= err_nx;
      if (mism && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      if (bad_go) bad_q <= 1'b1;
    end
  end

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = {23'd0, go_q, 3'd0, train_q, halt_q, mode_q};
      3'd1:    cfg_rdata = 32'(first_q);
      3'd2:    cfg_rdata = 32'(last_q);
      3'd3:    cfg_rdata = {1'b0, busy, 14'd0, err_q, 7'd0, bad_q};
      3'd4:    cfg_rdata = 32'(cnt_q);
      default: cfg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/memtest_seq_chk.sv
module memtest_seq_chk #(
  parameter int LINE_AW = 16,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ready,
  input logic [LINE_AW+2:0] mem_addr,
  input logic [63:0]        mem_wdata,
  input logic [2:0]         mode_q,
  input logic               go_q,
  input logic [7:0]         err_q,
  input logic [CNT_W-1:0]   cnt_q,
  input logic               cfg_we,
  input logic [2:0]         cfg_addr,
  input logic [31:0]        cfg_wdata
);
  wire clr_w  = cfg_we && cfg_addr == 3'd3 && cfg_wdata[12];
  wire bad_go = cfg_we && cfg_addr == 3'd0 && cfg_wdata[8] && cfg_wdata[2] && !go_q && !busy;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R13
  AST_INIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mode_q == 3'd0) |-> (mem_we && mem_wdata == 64'd0)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_w |=> ((err_q & $past(err_q)) == $past(err_q))); // R6
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == {CNT_W{1'b1}} && !clr_w) |=> cnt_q == {CNT_W{1'b1}}); // R11
  AST_BAD_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_go |=> !busy); // R12
endmodule

bind memtest_seq memtest_seq_chk #(.LINE_AW(LINE_AW), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mode_q(mode_q), .go_q(go_q), .err_q(err_q), .cnt_q(cnt_q),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata));

// File: tb/memtest_seq_tb_top.sv
`timescale 1ns/1ps
module memtest_seq_tb_top;
  localparam int LA = 4;
  localparam int CW = 4;
  localparam int NW = 8 << LA;
  localparam logic [63:0] BASE = 64'h5AA55AA55AA55AA5;
  localparam logic [63:0] INV  = 64'hA55AA55AA55AA55A;
  localparam logic [63:0] WTR  = 64'hC33C0000C33C0000;
  localparam logic [63:0] RTR  = 64'hAA5555AAAA5555AA;
  localparam logic [63:0] ONES = 64'hFFFFFFFFFFFFFFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic mem_req, mem_we, mem_ready = 1'b0;
  logic [LA+2:0] mem_addr;
  logic [63:0] mem_wdata, mem_rdata;
  logic [63:0] mem [0:NW-1];
  logic fault_all = 1'b0;
  logic [LA+2:0] fault_addr = '0;
  logic [63:0] fault_mask = '0;
  int checks = 0, fails = 0, beats = 0, rbeats = 0, cyc = 0;

  always #4 clk = ~clk;

  memtest_seq #(.LINE_AW(LA), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata));

  assign mem_rdata = mem[mem_addr] ^ ((fault_all || mem_addr == fault_addr) ? fault_mask : 64'd0);

  always @(negedge clk) begin
    cyc <= cyc + 1;
    mem_ready <= ((cyc % 3) != 2);
  end
  always @(posedge clk) begin
    if (mem_req && mem_ready) begin
      beats <= beats + 1;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else rbeats <= rbeats + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); cfg_addr = a; #1 v = cfg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 4000; k++) begin
      rd(3'd3, s);
      if (!s[30]) return;
    end
    chk(0, "R2 busy never fell", 1, 0);
  endtask

  task automatic run(input int f, input int l, input logic [31:0] ctrl);
    wr(3'd1, f); wr(3'd2, l); wr(3'd3, 32'h1000);
    wr(3'd0, ctrl & ~32'h100);
    @(negedge clk); beats = 0; rbeats = 0;
    wr(3'd0, ctrl | 32'h100);
    wait_idle();
  endtask

  task automatic fill(input logic [63:0] v);
    for (int i = 0; i < NW; i++) mem[i] = v;
  endtask

  task automatic mem_chk(input int f, input int l, input logic [63:0] vin, input logic [63:0] vout, input string tag);
    for (int i = 0; i < NW; i++)
      chk(mem[i] === ((i >= f*8 && i < l*8+8) ? vin : vout), tag, mem[i],
          (i >= f*8 && i < l*8+8) ? vin : vout);
  endtask

  task automatic stat_chk(input logic [31:0] es, input logic [31:0] ec, input string tag);
    logic [31:0] v;
    rd(3'd3, v); chk(v == es, {tag, " status"}, v, es);
    rd(3'd4, v); chk(v == ec, {tag, " count"}, v, ec);
  endtask

  initial begin
    logic [31:0] v;
    fill(ONES);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_req == 1'b0, "R1 req after reset", mem_req, 0);
    stat_chk(0, 0, "R1 reset");

    for (int f = 0; f < 16; f += 5)
      for (int n = 0; n < 3; n++) begin
        if (f + n > 15) continue;
        fill(ONES);
        fault_all = 1'b1; fault_mask = 64'hFF;
        run(f, f + n, 32'h0);
        fault_all = 1'b0; fault_mask = 0;
        chk(beats == 8*(n+1), "R3 init beats", beats, 8*(n+1));
        chk(rbeats == 0, "R3 init no reads", rbeats, 0);
        mem_chk(f, f + n, 64'd0, ONES, "R3 init contents");
        stat_chk(0, 0, "R3 init no compare");
        run(f, f + n, 32'h1);
        chk(beats == 32*(n+1), "R4 test beats", beats, 32*(n+1));
        chk(rbeats == 16*(n+1), "R4 test read beats", rbeats, 16*(n+1));
        mem_chk(f, f + n, INV, ONES, "R4 final pattern");
        stat_chk(0, 0, "R4 clean test");
      end

    fill(ONES);
    fault_addr = 7'(3*8 + 3); fault_mask = 64'hFF << 16;
    run(3, 5, 32'h1);
    chk(beats == 48, "R5 abort beats", beats, 48);
    mem_chk(3, 5, BASE, ONES, "R5 inverted pass skipped");
    stat_chk(32'h0400, 1, "R6 lane 2 flag");

    fill(ONES);
    run(3, 5, 32'h9);
    chk(beats == 24 + 4, "R8 halt beats", beats, 28);
    stat_chk(32'h0400, 1, "R8 halt status");
    fault_mask = 0;

    fill(ONES);
    fault_all = 1'b1; fault_mask = 64'hFF;
    run(0, 2, 32'h1);
    chk(beats == 48, "R11 abort beats", beats, 48);
    stat_chk(32'h0100, 15, "R11 saturation");
    wr(3'd3, 32'h1000);
    stat_chk(0, 0, "R7 clear");
    fault_all = 1'b0; fault_mask = 0;

    @(negedge clk); beats = 0;
    wr(3'd0, 32'h101);
    repeat (10) @(negedge clk);
    chk(beats == 0, "R2 repeated go ignored", beats, 0);

    fill(ONES);
    run(7, 0, 32'h2);
    chk(beats == 8, "R9 single write beats", beats, 8);
    mem_chk(7, 7, WTR, ONES, "R9 write-train constant");
    run(7, 0, 32'h12);
    mem_chk(7, 7, RTR, ONES, "R9 read-train constant");

    run(7, 0, 32'h13);
    chk(beats == 8 && rbeats == 8, "R10 single read beats", rbeats, 8);
    stat_chk(0, 0, "R10 match");
    fault_addr = 7'(60); fault_mask = 64'hFF << 56;
    run(7, 0, 32'h13);
    stat_chk(32'h8000, 1, "R10 lane 7");
    fault_mask = 0;
    run(7, 0, 32'h3);
    stat_chk(32'hFF00, 8, "R10 wrong constant");

    wr(3'd3, 32'h1000);
    wr(3'd0, 32'h5);
    @(negedge clk); beats = 0;
    wr(3'd0, 32'h105);
    rd(3'd3, v);
    chk(v == 32'h1, "R12 illegal mode status", v, 1);
    repeat (10) @(negedge clk);
    chk(beats == 0, "R12 no requests", beats, 0);
    wr(3'd3, 32'h1000);
    stat_chk(0, 0, "R7 clear illegal flag");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule